// File: doc/BRIEF.md
# YUV Chroma Sequencing Controller

This controller sits in front of a shared scaling filter that feeds a YUV-to-RGB converter. For each output line it decides which plane the filter reads next (U, V or Y). It gives the phase advance for every filter step, marks the steps that finish an output pixel, and tells the converter when to take fresh chroma. It also supplies the chroma line address. The filter arithmetic and the colour matrix live elsewhere.

Two sequencing modes exist. In the per-pixel chroma mode, chroma is upsampled to full resolution and every output pixel costs three filter steps (U, V, Y). In the pairwise mode, one chroma fetch serves two output pixels (U, V, Y, Y). That cuts the cost to two steps per pixel, but the converter only refreshes U and V on every second pixel. The pairwise mode is required when the output stays 4:2:2, and may be chosen for RGB output to save time. For 4:2:0 input, the chroma planes are half as tall as luma, so each chroma line serves two consecutive output lines.

A line begins with a start pulse while the controller is idle. The mode bits, pixel count, luma step and output line number are all captured at that moment. Steps are then presented with a valid/ready handshake until the line's last luma step is taken.

Top module: `chroma_seq_ctrl`

## Requirements
- R1: After reset, and whenever no line is in progress, `step_vld_o`, `px_end_o`, `cupd_o` and `line_end_o` are low.
- R2: A `line_start_i` sampled while idle with a nonzero `pix_count_i` makes `step_vld_o` high on the next cycle, with `comp_o` = U. A start pulse sampled during a line, or with a zero count, has no effect.
- R3: Component codes are Y = 2'b00, U = 2'b01, V = 2'b10. With `pair_mode_i` low, every pixel takes the steps U, V, Y. Each Y step has `px_end_o` and `cupd_o` high.
- R4: With `pair_mode_i` high, pixels are taken two at a time as U, V, Y, Y. Both Y steps have `px_end_o` high, but only the first has `cupd_o` high. When the pixel count is odd, the final group is U, V, Y.
- R5: `phase_inc_o` is in half-step units (one fractional LSB). A Y step carries twice `luma_step_i`. A V step carries 0. A U step carries `luma_step_i` in per-pixel mode and twice `luma_step_i` in pairwise mode.
- R6: `cline_o` is `out_line_i` shifted right by one when `in420_i` is high, and `out_line_i` otherwise. It is captured at an accepted start and held until the next accepted start.
- R7: Mode bits, pixel count, luma step and line number are used only as sampled at the accepted start. Changing them during a line does not alter the sequence.
- R8: While `step_rdy_i` is low, the presented step (component, increment and flags) is held unchanged.
- R9: `line_end_o` marks the last Y step of the line. Once that step is accepted, `step_vld_o` drops. With `step_rdy_i` held high, a line of N pixels keeps `step_vld_o` high for 3N cycles in per-pixel mode, and for 4*floor(N/2) + 3*(N mod 2) cycles in pairwise mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| line_start_i | input | 1 | Start a line (taken only when idle) |
| pair_mode_i | input | 1 | 1 = pairwise chroma (U,V,Y,Y), 0 = per-pixel (U,V,Y) |
| in420_i | input | 1 | Input chroma is 4:2:0; reuse each chroma line twice |
| pix_count_i | input | PIX_W | Output pixels in the line |
| luma_step_i | input | STEP_W | Luma phase step per output pixel |
| out_line_i | input | LINE_W | Output line number |
| step_rdy_i | input | 1 | Filter accepts the presented step |
| step_vld_o | output | 1 | A filter step is presented |
| comp_o | output | 2 | Plane for this step (Y 00, U 01, V 10) |
| phase_inc_o | output | STEP_W+1 | Phase advance in half-step units |
| px_end_o | output | 1 | This step completes an output pixel |
| cupd_o | output | 1 | Converter loads new U/V with this pixel |
| line_end_o | output | 1 | Last step of the line |
| cline_o | output | LINE_W | Chroma line address |

## Verification
Assertions check the local handshake and ordering rules on every cycle: a held step stays unchanged while not ready, an accepted U is followed by V and an accepted V by Y, an accepted start shows U, the line ends right after the marked last step, the chroma line address stays put mid-line, and a converter update only comes with a pixel end. The complete step list of a line can only be seen over a whole scenario. That includes the pair grouping, the odd-count tail, the increment per mode and the total cycle count. So do the immunity to input changes and stray starts mid-line, and the 4:2:0 line address. The bench compares each of these against a sequence it builds from the pixel count and modes.

// File: rtl/chroma_seq_pkg.sv
package chroma_seq_pkg;
  typedef enum logic [1:0] {
    CMP_Y = 2'b00,
    CMP_U = 2'b01,
    CMP_V = 2'b10
  } comp_e;

  typedef enum logic [1:0] {
    PH_U  = 2'd0,
    PH_V  = 2'd1,
    PH_Y0 = 2'd2,
    PH_Y1 = 2'd3
  } phase_e;
endpackage

// File: rtl/cseq_line_cfg.sv
// Captures per-line configuration at an accepted start; exposes the
// value in force for the coming cycle so outputs can be registered.
module cseq_line_cfg #(
  parameter int PIX_W  = 12,
  parameter int STEP_W = 16,
  parameter int LINE_W = 11
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_i,
  input  logic              pair_i,
  input  logic              in420_i,
  input  logic [PIX_W-1:0]  npix_i,
  input  logic [STEP_W-1:0] step_i,
  input  logic [LINE_W-1:0] line_i,
  output logic              pair_n_o,
  output logic [PIX_W-1:0]  npix_n_o,
  output logic [STEP_W-1:0] step_n_o,
  output logic [LINE_W-1:0] cline_o
);
  logic              pair_q;
  logic [PIX_W-1:0]  npix_q;
  logic [STEP_W-1:0] step_q;
  logic [LINE_W-1:0] cline_q;
  logic [LINE_W-1:0] cline_d;

  assign pair_n_o = load_i ? pair_i : pair_q;
  assign npix_n_o = load_i ? npix_i : npix_q;
  assign step_n_o = load_i ? step_i : step_q;
  assign cline_d  = in420_i ? (line_i >> 1) : line_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      pair_q  <= 1'b0;
      npix_q  <= '0;
      step_q  <= '0;
      cline_q <= '0;
    end else begin
      pair_q <= pair_n_o;
      npix_q <= npix_n_o;
      step_q <= step_n_o;
      if (load_i) cline_q <= cline_d;
    end
  end

  assign cline_o = cline_q;
endmodule

// File: rtl/cseq_step_fsm.sv
// Walks the U,V,Y(,Y) step order across a line and counts pixels.
module cseq_step_fsm
  import chroma_seq_pkg::*;
#(
  parameter int PIX_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic [PIX_W-1:0] start_cnt_i,
  input  logic             adv_i,
  input  logic [PIX_W-1:0] npix_i,
  input  logic             pair_i,
  output logic             load_o,
  output logic             busy_n_o,
  output phase_e           ph_n_o,
  output logic [PIX_W-1:0] pix_n_o
);
  localparam logic [PIX_W-1:0] PIX_ONE = PIX_W'(1);

  logic             busy_q;
  phase_e           ph_q;
  logic [PIX_W-1:0] pix_q;
  logic             last_pix;

  assign load_o   = start_i && !busy_q && (start_cnt_i != '0);
  assign last_pix = (pix_q == npix_i - PIX_ONE);

  always_comb begin
    busy_n_o = busy_q;
    ph_n_o   = ph_q;
    pix_n_o  = pix_q;
    if (!busy_q) begin
      if (load_o) begin
        busy_n_o = 1'b1;
        ph_n_o   = PH_U;
        pix_n_o  = '0;
      end
    end else if (adv_i) begin
      unique case (ph_q)
        PH_U: ph_n_o = PH_V;
        PH_V: ph_n_o = PH_Y0;
        PH_Y0: begin
          if (last_pix) begin
            busy_n_o = 1'b0;
            ph_n_o   = PH_U;
          end else begin
            ph_n_o  = pair_i ? PH_Y1 : PH_U;
            pix_n_o = pix_q + PIX_ONE;
          end
        end
        PH_Y1: begin
          if (last_pix) begin
            busy_n_o = 1'b0;
            ph_n_o   = PH_U;
          end else begin
            ph_n_o  = PH_U;
            pix_n_o = pix_q + PIX_ONE;
          end
        end
        default: ph_n_o = PH_U;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      ph_q   <= PH_U;
      pix_q  <= '0;
    end else begin
      busy_q <= busy_n_o;
      ph_q   <= ph_n_o;
      pix_q  <= pix_n_o;
    end
  end
endmodule

// File: rtl/cseq_step_decode.sv
// Maps a sequencer phase to component, increment and strobes.
module cseq_step_decode
  import chroma_seq_pkg::*;
#(
  parameter int PIX_W  = 12,
  parameter int STEP_W = 16
) (
  input  logic              busy_i,
  input  phase_e            ph_i,
  input  logic [PIX_W-1:0]  pix_i,
  input  logic [PIX_W-1:0]  npix_i,
  input  logic              pair_i,
  input  logic [STEP_W-1:0] step_i,
  output logic              vld_o,
  output comp_e             comp_o,
  output logic [STEP_W:0]   inc_o,
  output logic              px_end_o,
  output logic              cupd_o,
  output logic              lend_o
);
  localparam logic [PIX_W-1:0] PIX_ONE = PIX_W'(1);

  logic [STEP_W:0] inc_full;
  logic [STEP_W:0] inc_half;
  logic            is_y;

  assign inc_full = {step_i, 1'b0};
  assign inc_half = {1'b0, step_i};
  assign is_y     = (ph_i == PH_Y0) || (ph_i == PH_Y1);

  always_comb begin
    vld_o    = busy_i;
    comp_o   = CMP_Y;
    inc_o    = '0;
    px_end_o = 1'b0;
    cupd_o   = 1'b0;
    lend_o   = 1'b0;
    if (busy_i) begin
      unique case (ph_i)
        PH_U: begin
          comp_o = CMP_U;
          inc_o  = pair_i ? inc_full : inc_half;
        end
        PH_V: begin
          comp_o = CMP_V;
          inc_o  = '0;
        end
        default: begin
          comp_o = CMP_Y;
          inc_o  = inc_full;
        end
      endcase
      px_end_o = is_y;
      cupd_o   = (ph_i == PH_Y0);
      lend_o   = is_y && (pix_i == npix_i - PIX_ONE);
    end
  end
endmodule

// File: rtl/chroma_seq_ctrl.sv
module chroma_seq_ctrl
  import chroma_seq_pkg::*;
#(
  parameter int PIX_W  = 12,
  parameter int STEP_W = 16,
  parameter int LINE_W = 11
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              line_start_i,
  input  logic              pair_mode_i,
  input  logic              in420_i,
  input  logic [PIX_W-1:0]  pix_count_i,
  input  logic [STEP_W-1:0] luma_step_i,
  input  logic [LINE_W-1:0] out_line_i,
  input  logic              step_rdy_i,
  output logic              step_vld_o,
  output logic [1:0]        comp_o,
  output logic [STEP_W:0]   phase_inc_o,
  output logic              px_end_o,
  output logic              cupd_o,
  output logic              line_end_o,
  output logic [LINE_W-1:0] cline_o
);
  logic              load;
  logic              pair_n;
  logic [PIX_W-1:0]  npix_n;
  logic [STEP_W-1:0] step_n;
  logic              busy_n;
  phase_e            ph_n;
  logic [PIX_W-1:0]  pix_n;

  logic              d_vld;
  comp_e             d_comp;
  logic [STEP_W:0]   d_inc;
  logic              d_pxend;
  logic              d_cupd;
  logic              d_lend;

  logic              vld_q;
  comp_e             comp_q;
  logic [STEP_W:0]   inc_q;
  logic              pxend_q;
  logic              cupd_q;
  logic              lend_q;

  cseq_line_cfg #(
    .PIX_W (PIX_W),
    .STEP_W(STEP_W),
    .LINE_W(LINE_W)
  ) cfg_i (
    .clk     (clk),
    .rst     (rst),
    .load_i  (load),
    .pair_i  (pair_mode_i),
    .in420_i (in420_i),
    .npix_i  (pix_count_i),
    .step_i  (luma_step_i),
    .line_i  (out_line_i),
    .pair_n_o(pair_n),
    .npix_n_o(npix_n),
    .step_n_o(step_n),
    .cline_o (cline_o)
  );

  cseq_step_fsm #(
    .PIX_W(PIX_W)
  ) fsm_i (
    .clk        (clk),
    .rst        (rst),
    .start_i    (line_start_i),
    .start_cnt_i(pix_count_i),
    .adv_i      (step_rdy_i),
    .npix_i     (npix_n),
    .pair_i     (pair_n),
    .load_o     (load),
    .busy_n_o   (busy_n),
    .ph_n_o     (ph_n),
    .pix_n_o    (pix_n)
  );

  cseq_step_decode #(
    .PIX_W (PIX_W),
    .STEP_W(STEP_W)
  ) dec_i (
    .busy_i  (busy_n),
    .ph_i    (ph_n),
    .pix_i   (pix_n),
    .npix_i  (npix_n),
    .pair_i  (pair_n),
    .step_i  (step_n),
    .vld_o   (d_vld),
    .comp_o  (d_comp),
    .inc_o   (d_inc),
    .px_end_o(d_pxend),
    .cupd_o  (d_cupd),
    .lend_o  (d_lend)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q   <= 1'b0;
      comp_q  <= CMP_Y;
      inc_q   <= '0;
      pxend_q <= 1'b0;
      cupd_q  <= 1'b0;
      lend_q  <= 1'b0;
    end else begin
      vld_q   <= d_vld;
      comp_q  <= d_comp;
      inc_q   <= d_inc;
      pxend_q <= d_pxend;
      cupd_q  <= d_cupd;
      lend_q  <= d_lend;
    end
  end

  assign step_vld_o  = vld_q;
  assign comp_o      = comp_q;
  assign phase_inc_o = inc_q;
  assign px_end_o    = pxend_q;
  assign cupd_o      = cupd_q;
  assign line_end_o  = lend_q;
endmodule

// File: rtl/chroma_seq_ctrl_chk.sv
module chroma_seq_ctrl_chk #(
  parameter int PIX_W  = 12,
  parameter int STEP_W = 16,
  parameter int LINE_W = 11
) (
  input logic              clk,
  input logic              rst,
  input logic              line_start_i,
  input logic [PIX_W-1:0]  pix_count_i,
  input logic              step_rdy_i,
  input logic              step_vld_o,
  input logic [1:0]        comp_o,
  input logic [STEP_W:0]   phase_inc_o,
  input logic              px_end_o,
  input logic              cupd_o,
  input logic              line_end_o,
  input logic [LINE_W-1:0] cline_o
);
  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !step_vld_o |-> (!px_end_o && !line_end_o && !cupd_o));

  // R2
  start_shows_u_chk: assert property (@(posedge clk) disable iff (rst)
    (line_start_i && !step_vld_o && pix_count_i != '0) |=> (step_vld_o && comp_o == 2'b01));

  // R3
  u_then_v_chk: assert property (@(posedge clk) disable iff (rst)
    (step_vld_o && step_rdy_i && comp_o == 2'b01) |=> (step_vld_o && comp_o == 2'b10));

  // R3
  v_then_y_chk: assert property (@(posedge clk) disable iff (rst)
    (step_vld_o && step_rdy_i && comp_o == 2'b10) |=> (step_vld_o && comp_o == 2'b00));

  // R4
  cupd_on_pixel_chk: assert property (@(posedge clk) disable iff (rst)
    (step_vld_o && cupd_o) |-> px_end_o);

  // R6
  cline_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (step_vld_o && !(step_rdy_i && line_end_o)) |=> $stable(cline_o));

  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (step_vld_o && !step_rdy_i) |=> (step_vld_o && $stable(comp_o) &&
      $stable(phase_inc_o) && $stable(px_end_o) && $stable(cupd_o) && $stable(line_end_o)));

  // R9
  line_close_chk: assert property (@(posedge clk) disable iff (rst)
    (step_vld_o && step_rdy_i && line_end_o) |=> !step_vld_o);
endmodule

bind chroma_seq_ctrl chroma_seq_ctrl_chk #(
  .PIX_W (PIX_W),
  .STEP_W(STEP_W),
  .LINE_W(LINE_W)
) chk_i (
  .clk         (clk),
  .rst         (rst),
  .line_start_i(line_start_i),
  .pix_count_i (pix_count_i),
  .step_rdy_i  (step_rdy_i),
  .step_vld_o  (step_vld_o),
  .comp_o      (comp_o),
  .phase_inc_o (phase_inc_o),
  .px_end_o    (px_end_o),
  .cupd_o      (cupd_o),
  .line_end_o  (line_end_o),
  .cline_o     (cline_o)
);

// File: tb/chroma_seq_ctrl_tb_top.sv
module chroma_seq_ctrl_tb_top;
  localparam int PIX_W  = 12;
  localparam int STEP_W = 16;
  localparam int LINE_W = 11;
  localparam int MAXE   = 128;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              line_start_i = 1'b0;
  logic              pair_mode_i = 1'b0;
  logic              in420_i = 1'b0;
  logic [PIX_W-1:0]  pix_count_i = '0;
  logic [STEP_W-1:0] luma_step_i = '0;
  logic [LINE_W-1:0] out_line_i = '0;
  logic              step_rdy_i = 1'b0;
  logic              step_vld_o;
  logic [1:0]        comp_o;
  logic [STEP_W:0]   phase_inc_o;
  logic              px_end_o;
  logic              cupd_o;
  logic              line_end_o;
  logic [LINE_W-1:0] cline_o;

  int checks = 0;
  int fails  = 0;

  logic [1:0]      e_comp [MAXE];
  logic [STEP_W:0] e_inc  [MAXE];
  logic [2:0]      e_flg  [MAXE];
  int              e_n;

  always #2.5 clk = ~clk;

  chroma_seq_ctrl #(
    .PIX_W (PIX_W),
    .STEP_W(STEP_W),
    .LINE_W(LINE_W)
  ) dut_i (
    .clk         (clk),
    .rst         (rst),
    .line_start_i(line_start_i),
    .pair_mode_i (pair_mode_i),
    .in420_i     (in420_i),
    .pix_count_i (pix_count_i),
    .luma_step_i (luma_step_i),
    .out_line_i  (out_line_i),
    .step_rdy_i  (step_rdy_i),
    .step_vld_o  (step_vld_o),
    .comp_o      (comp_o),
    .phase_inc_o (phase_inc_o),
    .px_end_o    (px_end_o),
    .cupd_o      (cupd_o),
    .line_end_o  (line_end_o),
    .cline_o     (cline_o)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [LINE_W-1:0] exp_cline(input bit f420, input int line);
    logic [LINE_W-1:0] l;
    l = LINE_W'(line);
    return f420 ? (l >> 1) : l;
  endfunction

  // flags: {line_end, cupd, px_end}
  task automatic push(input logic [1:0] c, input logic [STEP_W:0] inc, input logic [2:0] f);
    e_comp[e_n] = c;
    e_inc[e_n]  = inc;
    e_flg[e_n]  = f;
    e_n++;
  endtask

  task automatic build(input int n, input bit pair, input int step);
    logic [STEP_W:0] full, half;
    int p;
    full = {STEP_W'(step), 1'b0};
    half = {1'b0, STEP_W'(step)};
    e_n = 0;
    p = 0;
    while (p < n) begin
      push(2'b01, pair ? full : half, 3'b000);
      push(2'b10, '0, 3'b000);
      push(2'b00, full, {(p == n - 1), 1'b1, 1'b1});
      p++;
      if (pair && p < n) begin
        push(2'b00, full, {(p == n - 1), 1'b0, 1'b1});
        p++;
      end
    end
  endtask

  task automatic run_line(input int n, input bit pair, input bit f420, input int line,
                          input int step, input bit rnd_rdy, input bit noise);
    int k, cyc;
    logic [LINE_W-1:0] ecl;
    bit rdy;
    build(n, pair, step);
    ecl = exp_cline(f420, line);
    @(negedge clk);
    line_start_i = 1'b1;
    pair_mode_i  = pair;
    in420_i      = f420;
    pix_count_i  = PIX_W'(n);
    luma_step_i  = STEP_W'(step);
    out_line_i   = LINE_W'(line);
    step_rdy_i   = 1'b0;
    @(negedge clk);
    line_start_i = 1'b0;
    // R2: first step after accepted start is U
    check(step_vld_o && comp_o == 2'b01, "R2 start", {step_vld_o, comp_o}, 3'b101);
    // R6
    check(cline_o == ecl, "R6 cline at start", cline_o, ecl);
    k = 0;
    cyc = 0;
    while (step_vld_o) begin
      cyc++;
      if (k < e_n)
        check(comp_o == e_comp[k] && phase_inc_o == e_inc[k] &&
              {line_end_o, cupd_o, px_end_o} == e_flg[k],
              pair ? "R4 R5 R7 R8 step" : "R3 R5 R7 R8 step",
              {comp_o, phase_inc_o, line_end_o, cupd_o, px_end_o},
              {e_comp[k], e_inc[k], e_flg[k]});
      else
        check(1'b0, "R9 overrun", k, e_n);
      if (noise) begin
        pair_mode_i  = 1'($urandom);
        in420_i      = 1'($urandom);
        pix_count_i  = PIX_W'($urandom % 24);
        luma_step_i  = STEP_W'($urandom);
        out_line_i   = LINE_W'($urandom);
        line_start_i = ($urandom % 4 == 0);
      end
      rdy = rnd_rdy ? ($urandom % 3 != 0) : 1'b1;
      step_rdy_i = rdy;
      if (rdy) k++;
      @(negedge clk);
    end
    line_start_i = 1'b0;
    step_rdy_i   = 1'b0;
    // R9
    check(k == e_n, "R9 step count", k, e_n);
    if (!rnd_rdy) check(cyc == e_n, "R9 cycles", cyc, e_n);
    // R6: held after line
    check(cline_o == ecl, "R6 cline held", cline_o, ecl);
    check(!px_end_o && !line_end_o && !cupd_o, "R1 idle flags",
          {px_end_o, line_end_o, cupd_o}, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1
    check(!step_vld_o && !px_end_o && !line_end_o && !cupd_o, "R1 reset",
          {step_vld_o, px_end_o, line_end_o, cupd_o}, 0);
    check(cline_o == '0, "R1 reset cline", cline_o, 0);

    // R2: zero count start ignored
    @(negedge clk);
    line_start_i = 1'b1;
    pix_count_i  = '0;
    out_line_i   = LINE_W'(9);
    @(negedge clk);
    line_start_i = 1'b0;
    check(!step_vld_o, "R2 zero count", step_vld_o, 0);
    check(cline_o == '0, "R2 zero count cline", cline_o, 0);

    // Directed cases
    run_line(1, 1'b0, 1'b0, 5, 16'h0100, 1'b0, 1'b0);   // R3 single pixel
    run_line(4, 1'b0, 1'b0, 6, 16'h0333, 1'b0, 1'b0);   // R3 R9 per-pixel
    run_line(1, 1'b1, 1'b0, 8, 16'h0200, 1'b0, 1'b0);   // R4 tail only
    run_line(2, 1'b1, 1'b1, 7, 16'h0180, 1'b0, 1'b0);   // R4 R6 odd line
    run_line(5, 1'b1, 1'b1, 2047, 16'hFFFF, 1'b0, 1'b0); // R4 odd count, R5 max step
    run_line(6, 1'b1, 1'b0, 2046, 16'h0001, 1'b1, 1'b1); // R7 R8 noise + stall
    run_line(3, 1'b0, 1'b1, 1, 16'h8000, 1'b1, 1'b1);   // R2 R7 stray starts

    // Random lines
    for (int i = 0; i < 40; i++) begin
      run_line(1 + int'($urandom % 20), 1'($urandom), 1'($urandom),
               int'($urandom % 2048), int'($urandom % 65536),
               1'($urandom), 1'($urandom));
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule